// File: doc/BRIEF.md
# Processor Idle State Controller

This block follows a processor core through its three idle levels (running, auto-halt and stop-grant) and drives the clock-enable and handshake signals that go with each level. The core enters auto-halt by pulsing a halt line. It enters the deeper stop-grant level only when software reads a programmable power-level port address on a small I/O bus. In stop-grant the block raises a request and waits a bounded number of cycles for the core's acknowledge before gating the clock. If the acknowledge never arrives, it settles for auto-halt instead.

Four kinds of break event send the core back to the running level: an unmasked interrupt, a pending NMI or SMI (the SMI line is active-low), an active-low pending-break line and a message-signalled interrupt. A sticky register records which of them caused each exit. A 2-bit system sleep input either leaves the system clocks running (S0) or powers the core down. When the core is powered down, only the always-on real-time and ring-oscillator domains stay alive, and those lie outside this block.

The state machine has six states:
- RUN: C0, code executing.
- HALT: C1, clock gated, no handshake.
- GREQ: stop-grant requested, waiting for the acknowledge.
- GRANT: C2, clock gated, request held.
- WAKE: clock back on, settling.
- OFF: the system is in a sleep state.

Its transitions are:
- RUN→HALT on a halt pulse.
- RUN→GREQ on a power-level read.
- GREQ→GRANT on an acknowledge.
- GREQ→HALT when the acknowledge wait expires.
- HALT→RUN and GREQ→RUN on a break.
- GRANT→WAKE on a break.
- WAKE→RUN when settling completes.
- Any state→OFF while the sleep input is non-zero.
- OFF→WAKE when the sleep input returns to zero.

Top module: `core_idle_ctrl`

## Requirements
- R1: After reset the controller is in RUN. Reset also sets:
  - `core_clk_en_o`, `sys_clk_en_o` and `core_running_o` to 1, and `stpgnt_req_o` to 0.
  - The power-level base register (word at CSR_BASE+0) to 16'h0414.
  - The acknowledge limit (word at CSR_BASE+1, 8 bits) to 16.
  - The break flags (word at CSR_BASE+3) to 0.
- R2: In RUN with the sleep input at 0 and no break, a one-cycle `core_halt_i` moves the block to HALT on the next edge. HALT gates the core clock, keeps `stpgnt_req_o` low and reports status code 1.
- R3: A read whose address equals the power-level base register is handled as follows:
  - The read returns 0.
  - In RUN with no break, it moves the block to GREQ. GREQ raises `stpgnt_req_o` while the core clock stays on.
  - A write to that address, or a read of any other address, starts no entry.
- R4: In GREQ, a high `core_ack_i` moves the block to GRANT. GRANT gates the core clock, keeps `stpgnt_req_o` high and reports status code 2.
- R5: If no acknowledge arrives within max(L,1) cycles of GREQ, where L is the acknowledge limit, the block falls back to HALT. The request drops and the clock is gated.
- R6: A break event in HALT or GREQ returns the block to RUN on the next edge with the clock enabled. A break event is any of: `irq_i`=1, `nmi_i`=1, `smi_n_i`=0, `pbe_n_i`=0 or `msi_i`=1.
- R7: A break in GRANT enters WAKE. WAKE enables the clock, drops the request and holds `core_running_o` low for exactly SETTLE (4) cycles before RUN.
- R8: On each break-driven exit, the break flags OR in the active sources. The flag bits are: bit0 interrupt, bit1 NMI/SMI, bit2 pending-break, bit3 MSI. Writing 1 to a flag bit clears it. A break seen in RUN sets no flag.
- R9: A break in the same cycle as a halt pulse or a power-level read, while in RUN, blocks the entry and the block stays in RUN.
- R10: A non-zero `sleep_state_i` moves the block to OFF on the next edge. The encoding is 0=S0, 1=S3, 2=S4, 3=S5. OFF behaves as follows:
  - The core and system clock enables drop and the status code is 3.
  - Halt pulses and power-level reads are ignored.
  - When the input returns to 0, the block passes through WAKE to RUN.
- R11: The power-level base (CSR_BASE+0) and the acknowledge limit (CSR_BASE+1) can be read back after a write. Once the base is written, only reads of the new address start an entry. The status word (CSR_BASE+2) holds the C-state code in bits 1:0 and the running flag in bit 2. Status codes are 0 for RUN/GREQ/WAKE, 1 for HALT, 2 for GRANT and 3 for OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_halt_i | input | 1 | One-cycle halt pulse from the core |
| core_ack_i | input | 1 | Stop-grant acknowledge from the core |
| irq_i | input | 1 | Unmasked interrupt active |
| nmi_i | input | 1 | Pending NMI |
| smi_n_i | input | 1 | Pending SMI, active low |
| pbe_n_i | input | 1 | Pending break event, active low |
| msi_i | input | 1 | Message-signalled interrupt |
| sleep_state_i | input | 2 | System sleep state: 0=S0, 1=S3, 2=S4, 3=S5 |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_addr_i | input | 16 | I/O word address |
| io_wdata_i | input | 16 | I/O write data |
| io_rdata_o | output | 16 | I/O read data, combinational, 0 when not reading |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_clk_en_o | output | 1 | System clock enable, low in sleep states |
| stpgnt_req_o | output | 1 | Stop-grant request |
| core_running_o | output | 1 | Core is in RUN and settled |

## Verification
The bench aims at several corner cases, each paired with the failure it would expose:
- A break arriving in the same cycle as a halt pulse or a power-level read. A design that let the entry win would gate the clock while an interrupt is pending.
- An acknowledge wait that expires, including the zero limit. An off-by-one counter would hold the request one cycle too long or too short, and a missing fallback would leave the core stuck in GREQ.
- Exit from GRANT. This must take exactly four settle cycles with the request dropped and `core_running_o` low.
- The sticky flags. These must collect each source with the right polarity, ignore breaks in RUN and clear only the bits written with 1.
- Sleep entry and exit. Halts must be ignored while in OFF, and the return path must go through settling.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;

    // Controller states
    typedef enum logic [2:0] {
        IS_RUN   = 3'd0,
        IS_HALT  = 3'd1,
        IS_GREQ  = 3'd2,
        IS_GRANT = 3'd3,
        IS_WAKE  = 3'd4,
        IS_OFF   = 3'd5
    } idle_state_e;

    // Reported C-state codes
    typedef enum logic [1:0] {
        CS_C0  = 2'd0,
        CS_C1  = 2'd1,
        CS_C2  = 2'd2,
        CS_OFF = 2'd3
    } cstate_e;

    localparam int NUM_BRK     = 4;
    localparam int BRK_IRQ     = 0;
    localparam int BRK_NMI_SMI = 1;
    localparam int BRK_PBE     = 2;
    localparam int BRK_MSI     = 3;

endpackage

// File: rtl/core_idle_brk.sv
module core_idle_brk
    import core_idle_pkg::*;
(
    input  logic               irq,
    input  logic               nmi,
    input  logic               smi_n,
    input  logic               pbe_n,
    input  logic               msi,
    output logic [NUM_BRK-1:0] src,
    output logic               any
);

    always_comb begin
        src              = '0;
        src[BRK_IRQ]     = irq;
        src[BRK_NMI_SMI] = nmi | ~smi_n;
        src[BRK_PBE]     = ~pbe_n;
        src[BRK_MSI]     = msi;
    end

    assign any = |src;

endmodule

// File: rtl/core_idle_regs.sv
module core_idle_regs
    import core_idle_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 16,
    parameter logic [15:0]     CSR_BASE  = 16'h0400,
    parameter logic [15:0]     LVL_RST   = 16'h0414,
    parameter int              LIMIT_W   = 8,
    parameter int              LIMIT_RST = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_rd,
    input  logic               io_wr,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [DATA_W-1:0]  io_wdata,
    input  logic               exit_evt,
    input  logic [NUM_BRK-1:0] exit_src,
    input  cstate_e            cstate,
    input  logic               running,
    output logic [DATA_W-1:0]  rdata,
    output logic               lvl_rd,
    output logic [ADDR_W-1:0]  lvl_base,
    output logic [LIMIT_W-1:0] ack_limit
);

    localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(CSR_BASE);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(CSR_BASE + 16'd1);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(CSR_BASE + 16'd2);
    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(CSR_BASE + 16'd3);

    logic               lvl_hit;
    logic [NUM_BRK-1:0] flags_q;

    assign lvl_hit = (io_addr == lvl_base);
    assign lvl_rd  = io_rd && lvl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_base  <= ADDR_W'(LVL_RST);
            ack_limit <= LIMIT_W'(LIMIT_RST);
        end else if (io_wr) begin
            if (io_addr == A_BASE)  lvl_base  <= io_wdata[ADDR_W-1:0];
            if (io_addr == A_LIMIT) ack_limit <= io_wdata[LIMIT_W-1:0];
        end
    end

    // Sticky break flags: set on exit wins over write-one-to-clear
    for (genvar i = 0; i < NUM_BRK; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (exit_evt && exit_src[i]) begin
                flags_q[i] <= 1'b1;
            end else if (io_wr && io_addr == A_FLAG && io_wdata[i]) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (io_rd && !lvl_hit) begin
            unique case (io_addr)
                A_BASE:  rdata[ADDR_W-1:0]  = lvl_base;
                A_LIMIT: rdata[LIMIT_W-1:0] = ack_limit;
                A_STAT:  rdata[2:0]         = {running, cstate};
                A_FLAG:  rdata[NUM_BRK-1:0] = flags_q;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/core_idle_fsm.sv
module core_idle_fsm
    import core_idle_pkg::*;
#(
    parameter int LIMIT_W = 8,
    parameter int SETTLE  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt,
    input  logic               lvl_rd,
    input  logic               brk_any,
    input  logic               ack,
    input  logic               sleep_req,
    input  logic [LIMIT_W-1:0] ack_limit,
    output logic               core_clk_en,
    output logic               sys_clk_en,
    output logic               stpgnt_req,
    output logic               running,
    output cstate_e            cstate,
    output logic               exit_evt
);

    localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);

    idle_state_e        state_q, state_d;
    logic [LIMIT_W-1:0] wait_q;
    logic [SW-1:0]      settle_q;
    logic               expire;
    logic               settled;

    assign expire  = ({1'b0, wait_q} + 1'b1) >= {1'b0, ack_limit};
    assign settled = (settle_q == SETTLE_LAST);

    // State register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= IS_RUN;
            wait_q   <= '0;
            settle_q <= '0;
        end else begin
            state_q  <= state_d;
            wait_q   <= (state_q == IS_GREQ) ? wait_q + 1'b1 : '0;
            settle_q <= (state_q == IS_WAKE) ? settle_q + 1'b1 : '0;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        exit_evt = 1'b0;
        if (sleep_req) begin
            state_d = IS_OFF;
        end else begin
            unique case (state_q)
                IS_RUN: begin
                    if (!brk_any) begin
                        if (lvl_rd)    state_d = IS_GREQ;
                        else if (halt) state_d = IS_HALT;
                    end
                end
                IS_HALT: begin
                    if (brk_any) begin
                        state_d  = IS_RUN;
                        exit_evt = 1'b1;
                    end
                end
                IS_GREQ: begin
                    if (brk_any) begin
                        state_d  = IS_RUN;
                        exit_evt = 1'b1;
                    end else if (ack) begin
                        state_d = IS_GRANT;
                    end else if (expire) begin
                        state_d = IS_HALT;
                    end
                end
                IS_GRANT: begin
                    if (brk_any) begin
                        state_d  = IS_WAKE;
                        exit_evt = 1'b1;
                    end
                end
                IS_WAKE: if (settled) state_d = IS_RUN;
                IS_OFF:  state_d = IS_WAKE;
                default: state_d = IS_RUN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        core_clk_en = 1'b1;
        sys_clk_en  = 1'b1;
        stpgnt_req  = 1'b0;
        running     = 1'b0;
        cstate      = CS_C0;
        unique case (state_q)
            IS_RUN:   running = 1'b1;
            IS_HALT: begin
                core_clk_en = 1'b0;
                cstate      = CS_C1;
            end
            IS_GREQ:  stpgnt_req = 1'b1;
            IS_GRANT: begin
                core_clk_en = 1'b0;
                stpgnt_req  = 1'b1;
                cstate      = CS_C2;
            end
            IS_WAKE:  cstate = CS_C0;
            IS_OFF: begin
                core_clk_en = 1'b0;
                sys_clk_en  = 1'b0;
                cstate      = CS_OFF;
            end
            default:  running = 1'b0;
        endcase
    end

endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
    import core_idle_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] CSR_BASE  = 16'h0400,
    parameter logic [15:0] LVL_RST   = 16'h0414,
    parameter int          LIMIT_W   = 8,
    parameter int          LIMIT_RST = 16,
    parameter int          SETTLE    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_halt_i,
    input  logic              core_ack_i,
    input  logic              irq_i,
    input  logic              nmi_i,
    input  logic              smi_n_i,
    input  logic              pbe_n_i,
    input  logic              msi_i,
    input  logic [1:0]        sleep_state_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic [DATA_W-1:0] io_wdata_i,
    output logic [DATA_W-1:0] io_rdata_o,
    output logic              core_clk_en_o,
    output logic              sys_clk_en_o,
    output logic              stpgnt_req_o,
    output logic              core_running_o
);

    logic [NUM_BRK-1:0] brk_src;
    logic               brk_any;
    logic               lvl_rd;
    logic [ADDR_W-1:0]  lvl_base;
    logic [LIMIT_W-1:0] ack_limit;
    logic               exit_evt;
    cstate_e            cstate;

    core_idle_brk u_brk (
        .irq   (irq_i),
        .nmi   (nmi_i),
        .smi_n (smi_n_i),
        .pbe_n (pbe_n_i),
        .msi   (msi_i),
        .src   (brk_src),
        .any   (brk_any)
    );

    core_idle_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CSR_BASE  (CSR_BASE),
        .LVL_RST   (LVL_RST),
        .LIMIT_W   (LIMIT_W),
        .LIMIT_RST (LIMIT_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_rd     (io_rd_i),
        .io_wr     (io_wr_i),
        .io_addr   (io_addr_i),
        .io_wdata  (io_wdata_i),
        .exit_evt  (exit_evt),
        .exit_src  (brk_src),
        .cstate    (cstate),
        .running   (core_running_o),
        .rdata     (io_rdata_o),
        .lvl_rd    (lvl_rd),
        .lvl_base  (lvl_base),
        .ack_limit (ack_limit)
    );

    core_idle_fsm #(
        .LIMIT_W (LIMIT_W),
        .SETTLE  (SETTLE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt        (core_halt_i),
        .lvl_rd      (lvl_rd),
        .brk_any     (brk_any),
        .ack         (core_ack_i),
        .sleep_req   (sleep_state_i != 2'd0),
        .ack_limit   (ack_limit),
        .core_clk_en (core_clk_en_o),
        .sys_clk_en  (sys_clk_en_o),
        .stpgnt_req  (stpgnt_req_o),
        .running     (core_running_o),
        .cstate      (cstate),
        .exit_evt    (exit_evt)
    );

endmodule

// File: rtl/core_idle_ctrl_chk.sv
module core_idle_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int SETTLE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_halt_i,
    input logic              irq_i,
    input logic              nmi_i,
    input logic              smi_n_i,
    input logic              pbe_n_i,
    input logic              msi_i,
    input logic [1:0]        sleep_state_i,
    input logic              io_rd_i,
    input logic [ADDR_W-1:0] io_addr_i,
    input logic [ADDR_W-1:0] lvl_base,
    input logic [1:0]        cstate,
    input logic              core_clk_en_o,
    input logic              sys_clk_en_o,
    input logic              stpgnt_req_o,
    input logic              core_running_o
);

    logic brk;
    logic s0;
    logic in_wake;
    int   wake_len;

    assign brk     = irq_i | nmi_i | ~smi_n_i | ~pbe_n_i | msi_i;
    assign s0      = (sleep_state_i == 2'd0);
    assign in_wake = core_clk_en_o && !stpgnt_req_o && !core_running_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wake_len <= 0;
        else if (in_wake) wake_len <= wake_len + 1;
        else              wake_len <= 0;
    end

    assert_c1_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == 2'd1) |-> (!core_clk_en_o && !stpgnt_req_o));

    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_running_o && core_halt_i && !brk && s0 && !io_rd_i) |=> (cstate == 2'd1));

    assert_lvl_read_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_running_o && io_rd_i && io_addr_i == lvl_base && !brk && s0)
        |=> (stpgnt_req_o && core_clk_en_o));

    assert_c2_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == 2'd2) |-> (!core_clk_en_o && stpgnt_req_o));

    assert_break_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == 2'd1 && brk && s0) |=> (core_running_o && core_clk_en_o));

    assert_c2_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == 2'd2 && brk && s0) |=> (core_clk_en_o && !stpgnt_req_o && !core_running_o));

    assert_settle_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_len <= SETTLE);

    assert_break_blocks_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_running_o && brk && s0) |=> core_running_o);

    assert_off_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == 2'd3) |-> (!core_clk_en_o && !sys_clk_en_o));

endmodule

bind core_idle_ctrl core_idle_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .SETTLE (SETTLE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_halt_i    (core_halt_i),
    .irq_i          (irq_i),
    .nmi_i          (nmi_i),
    .smi_n_i        (smi_n_i),
    .pbe_n_i        (pbe_n_i),
    .msi_i          (msi_i),
    .sleep_state_i  (sleep_state_i),
    .io_rd_i        (io_rd_i),
    .io_addr_i      (io_addr_i),
    .lvl_base       (lvl_base),
    .cstate         (cstate),
    .core_clk_en_o  (core_clk_en_o),
    .sys_clk_en_o   (sys_clk_en_o),
    .stpgnt_req_o   (stpgnt_req_o),
    .core_running_o (core_running_o)
);

// File: tb/core_idle_ctrl_tb.sv
`timescale 1ns/1ps
module core_idle_ctrl_tb;

    localparam logic [15:0] CSR    = 16'h0400;
    localparam int          SETTLE = 4;

    // model states
    localparam int M_RUN = 0, M_HALT = 1, M_GREQ = 2, M_GRANT = 3, M_WAKE = 4, M_OFF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_halt_i = 1'b0, core_ack_i = 1'b0;
    logic        irq_i = 1'b0, nmi_i = 1'b0, smi_n_i = 1'b1, pbe_n_i = 1'b1, msi_i = 1'b0;
    logic [1:0]  sleep_state_i = 2'd0;
    logic        io_rd_i = 1'b0, io_wr_i = 1'b0;
    logic [15:0] io_addr_i = '0, io_wdata_i = '0;
    logic [15:0] io_rdata_o;
    logic        core_clk_en_o, sys_clk_en_o, stpgnt_req_o, core_running_o;

    always #5 clk = ~clk;

    core_idle_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .core_halt_i(core_halt_i), .core_ack_i(core_ack_i),
        .irq_i(irq_i), .nmi_i(nmi_i), .smi_n_i(smi_n_i), .pbe_n_i(pbe_n_i), .msi_i(msi_i),
        .sleep_state_i(sleep_state_i), .io_rd_i(io_rd_i), .io_wr_i(io_wr_i),
        .io_addr_i(io_addr_i), .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o),
        .core_clk_en_o(core_clk_en_o), .sys_clk_en_o(sys_clk_en_o),
        .stpgnt_req_o(stpgnt_req_o), .core_running_o(core_running_o)
    );

    int    m_st = M_RUN, m_wait = 0, m_settle = 0, m_flags = 0, m_base = 16'h0414, m_limit = 16;
    int    n_cmp = 0, n_bad = 0;
    string cur = "R1";

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", cur, what, act, exp);
        end
    endtask

    function automatic int m_code();
        case (m_st)
            M_HALT:  return 1;
            M_GRANT: return 2;
            M_OFF:   return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int m_rdata();
        if (!io_rd_i) return 0;
        if (int'(io_addr_i) == m_base) return 0;
        if (io_addr_i == CSR)      return m_base;
        if (io_addr_i == CSR + 1)  return m_limit;
        if (io_addr_i == CSR + 2)  return ((m_st == M_RUN) ? 4 : 0) + m_code();
        if (io_addr_i == CSR + 3)  return m_flags;
        return 0;
    endfunction

    task automatic model_tick();
        int src;
        bit brk, lvl, ex;
        if (!rst_n) begin
            m_st = M_RUN; m_wait = 0; m_settle = 0; m_flags = 0; m_base = 16'h0414; m_limit = 16;
            return;
        end
        src = (irq_i ? 1 : 0) + ((nmi_i || !smi_n_i) ? 2 : 0) + (!pbe_n_i ? 4 : 0) + (msi_i ? 8 : 0);
        brk = (src != 0);
        lvl = io_rd_i && (int'(io_addr_i) == m_base);
        ex  = 0;
        if (io_wr_i) begin
            if (io_addr_i == CSR)     m_base  = io_wdata_i;
            if (io_addr_i == CSR + 1) m_limit = io_wdata_i[7:0];
            if (io_addr_i == CSR + 3) m_flags = m_flags & ~int'(io_wdata_i[3:0]);
        end
        if (sleep_state_i != 0) m_st = M_OFF;
        else case (m_st)
            M_RUN: if (!brk) begin
                if (lvl) begin m_st = M_GREQ; m_wait = 0; end
                else if (core_halt_i) m_st = M_HALT;
            end
            M_HALT: if (brk) begin m_st = M_RUN; ex = 1; end
            M_GREQ: begin
                if (brk) begin m_st = M_RUN; ex = 1; end
                else if (core_ack_i) m_st = M_GRANT;
                else if (m_wait + 1 >= m_limit) m_st = M_HALT;
                else m_wait++;
            end
            M_GRANT: if (brk) begin m_st = M_WAKE; m_settle = 0; ex = 1; end
            M_WAKE: if (m_settle == SETTLE - 1) m_st = M_RUN; else m_settle++;
            default: begin m_st = M_WAKE; m_settle = 0; end
        endcase
        if (ex) m_flags = m_flags | src;
    endtask

    task automatic step();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk("core_clk_en", core_clk_en_o, (m_st == M_RUN || m_st == M_GREQ || m_st == M_WAKE) ? 1 : 0);
        chk("sys_clk_en", sys_clk_en_o, (m_st != M_OFF) ? 1 : 0);
        chk("stpgnt_req", stpgnt_req_o, (m_st == M_GREQ || m_st == M_GRANT) ? 1 : 0);
        chk("core_running", core_running_o, (m_st == M_RUN) ? 1 : 0);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic rd(logic [15:0] a);
        io_rd_i = 1'b1; io_addr_i = a;
        #1;
        chk("rdata", io_rdata_o, m_rdata());
        step();
        io_rd_i = 1'b0; io_addr_i = 16'h0000;
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] d);
        io_wr_i = 1'b1; io_addr_i = a; io_wdata_i = d;
        step();
        io_wr_i = 1'b0; io_addr_i = 16'h0000; io_wdata_i = '0;
    endtask

    task automatic halt_pulse();
        core_halt_i = 1'b1; step(); core_halt_i = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        cur = "R1";
        steps(3);
        rst_n = 1'b1;
        step();
        rd(CSR); rd(CSR + 1); rd(CSR + 2); rd(CSR + 3);

        // R2: halt pulse to C1
        cur = "R2";
        halt_pulse(); steps(2); rd(CSR + 2);
        // R6 + R8: interrupt exits C1 and sets flag bit0
        cur = "R6"; irq_i = 1'b1; step(); irq_i = 1'b0; step();
        cur = "R8"; rd(CSR + 3); wr(CSR + 3, 16'h0001); rd(CSR + 3);

        // R3: write to the level address and a read elsewhere do not enter
        cur = "R3";
        wr(16'h0414, 16'hFFFF); step(); rd(16'h0415); step();
        rd(16'h0414); steps(2);
        // R4: acknowledge after three cycles
        cur = "R4";
        core_ack_i = 1'b1; step(); core_ack_i = 1'b0; steps(3); rd(CSR + 2);
        // R7: MSI wakes from C2 through settle
        cur = "R7";
        msi_i = 1'b1; step(); msi_i = 1'b0; steps(6);
        cur = "R8"; rd(CSR + 3);

        // R5: timeout with limit 5, then pending-break exit
        cur = "R5";
        wr(CSR + 1, 16'd5); rd(CSR + 1); rd(16'h0414); steps(7); rd(CSR + 2);
        cur = "R6"; pbe_n_i = 1'b0; step(); pbe_n_i = 1'b1; step();
        // R5: limit 0 behaves as 1
        cur = "R5";
        wr(CSR + 1, 16'd0); rd(16'h0414); steps(2);
        cur = "R6"; irq_i = 1'b1; step(); irq_i = 1'b0; step();

        // R6: NMI aborts stop-grant entry
        cur = "R6";
        wr(CSR + 1, 16'd20); rd(16'h0414); step(); nmi_i = 1'b1; step(); nmi_i = 1'b0; steps(2);
        cur = "R8"; rd(CSR + 3); wr(CSR + 3, 16'h000F); rd(CSR + 3);

        // R9: break with halt or level read blocks entry, sets no flag
        cur = "R9";
        irq_i = 1'b1; core_halt_i = 1'b1; step(); core_halt_i = 1'b0;
        io_rd_i = 1'b1; io_addr_i = 16'h0414; step(); io_rd_i = 1'b0; irq_i = 1'b0;
        steps(2); rd(CSR + 3);

        // R6/R8: SMI (active low) exits C1, flag bit1
        cur = "R8";
        halt_pulse(); step(); smi_n_i = 1'b0; step(); smi_n_i = 1'b1; step(); rd(CSR + 3);

        // R10: sleep state powers the core off
        cur = "R10";
        sleep_state_i = 2'd1; steps(2); halt_pulse(); rd(CSR + 2); rd(16'h0414);
        sleep_state_i = 2'd3; steps(2);
        sleep_state_i = 2'd0; steps(7);

        // R11: base reprogramming
        cur = "R11";
        wr(CSR, 16'h0520); rd(CSR); rd(16'h0414); steps(2);
        rd(16'h0520); core_ack_i = 1'b1; step(); core_ack_i = 1'b0; step(); rd(CSR + 2);
        msi_i = 1'b1; step(); msi_i = 1'b0; steps(6); rd(CSR + 2);

        summary();
        $finish;
    end

endmodule